// File: doc/BRIEF.md
# Adder with Post-Shift Network

This block adds two unsigned operands and passes the sum straight into a combinational shifter. The shifter can move the sum by zero to three places in one step. Two separate result buses come out of the shifter. One carries the sum shifted toward the most significant end. The other carries it shifted toward the least significant end. Each bus has its own enable and reads all zeros while that enable is low. The carry out of the addition is brought out directly and is never shifted.

Each result bit is a multiplexer with an enable. Its select lines are the shift count. Its data inputs are sum bits, with constant zero where a bit would come from outside the word. The block has no state and no clock. Outputs follow the inputs after the combinational delay. The house streaming convention does not apply, because nothing here is held or handed over. No valid/ready pins exist and no back-pressure is possible.

Top module: `addshf_top`

## Requirements
- R1: The internal sum is (op_a + op_b) mod 2^DATA_W with a carry input of zero. With left_en=1 and shamt=0, left_out equals that sum.
- R2: carry_out is bit DATA_W of op_a + op_b. It does not depend on shamt, left_en or right_en.
- R3: With left_en=1, left_out = (sum << shamt) mod 2^DATA_W. The shift drops the upper bits and fills the vacated low bits with 0.
- R4: With right_en=1, right_out = sum >> shamt. The shift drops the low bits and fills the vacated high bits with 0.
- R5: With left_en=0, left_out is all zeros for every operand and count.
- R6: With right_en=0, right_out is all zeros for every operand and count.
- R7: The two enables act independently. With both high, each bus still carries its own shifted value.
- R8: With shamt=3 (the largest count), left_out has sum bit 0 in bit 3 and zeros elsewhere. right_out has sum bit 3 in bit 0 and zeros elsewhere.
- R9: With shamt=0 and its enable high, a result bus equals the unshifted sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | DATA_W | First addend |
| op_b | input | DATA_W | Second addend |
| shamt | input | CNT_W | Shift distance, 0 to 2^CNT_W-1 |
| left_en | input | 1 | Enables the left-shifted result bus |
| right_en | input | 1 | Enables the right-shifted result bus |
| left_out | output | DATA_W | Sum shifted toward the MSB, zero-filled |
| right_out | output | DATA_W | Sum shifted toward the LSB, zero-filled |
| carry_out | output | 1 | Carry out of the addition |

## Verification
The bench builds the block with its default parameters: a 4-bit data width and a 2-bit count. These defaults keep the whole input space small enough to sweep. The sweep covers all 256 operand pairs, under each of the four shift counts and each of the four enable pairs. It therefore reaches every dropped-bit and zero-fill position on both buses, every carry case, and both enables low together. The outputs are compared against integer arithmetic after each change of stimulus.

// File: rtl/addshf_pkg.sv
`timescale 1ns/1ps
package addshf_pkg;
  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } shift_dir_e;

  localparam int DEF_DATA_W = 4;
endpackage

// File: rtl/addshf_adder.sv
`timescale 1ns/1ps
module addshf_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] chain;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p;
    logic g;
    assign p          = a[i] ^ b[i];
    assign g          = a[i] & b[i];
    assign sum[i]     = p ^ chain[i];
    assign chain[i+1] = g | (p & chain[i]);
  end

  assign cout = chain[W];

  always_comb begin : chk
    // R1 / R2: the ripple chain must agree with integer addition
    p_add_matches_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b}));
  end
endmodule

// File: rtl/addshf_mux.sv
`timescale 1ns/1ps
module addshf_mux #(
  parameter int SEL_W = 2,
  localparam int N    = 1 << SEL_W
) (
  input  logic [N-1:0]     data,
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  output logic             y
);
  always_comb begin
    if (en) y = data[sel];
    else    y = 1'b0;
  end
endmodule

// File: rtl/addshf_shifter.sv
`timescale 1ns/1ps
module addshf_shifter
  import addshf_pkg::*;
#(
  parameter int         W     = 4,
  parameter int         CNT_W = 2,
  parameter shift_dir_e DIR   = DIR_LEFT,
  localparam int        TAPS  = 1 << CNT_W
) (
  input  logic [W-1:0]     din,
  input  logic [CNT_W-1:0] cnt,
  input  logic             en,
  output logic [W-1:0]     dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [TAPS-1:0] taps;
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      if (DIR == DIR_LEFT) begin : g_l
        if (i >= k) begin : g_src
          assign taps[k] = din[i-k];
        end else begin : g_zero
          assign taps[k] = 1'b0;
        end
      end else begin : g_r
        if (i + k < W) begin : g_src
          assign taps[k] = din[i+k];
        end else begin : g_zero
          assign taps[k] = 1'b0;
        end
      end
    end
    addshf_mux #(.SEL_W(CNT_W)) u_mux (
      .data (taps),
      .sel  (cnt),
      .en   (en),
      .y    (dout[i])
    );
  end

  always_comb begin : chk_common
    if (!en) begin
      // R5 on the left instance, R6 on the right instance
      p_disabled_zero_r5: assert (dout == '0);
    end
    if (en && cnt == '0) begin
      p_zero_count_pass_r9: assert (dout == din);
    end
  end

  if (DIR == DIR_LEFT) begin : g_chk_l
    always_comb begin
      if (en) begin
        p_left_shift_r3: assert (dout == W'(din << cnt));
      end
    end
    if (TAPS == W) begin : g_edge
      always_comb begin
        if (en && cnt == CNT_W'(TAPS - 1)) begin
          p_left_edge_r8: assert (dout == {din[0], {(W-1){1'b0}}});
        end
      end
    end
  end else begin : g_chk_r
    always_comb begin
      if (en) begin
        p_right_shift_r4: assert (dout == (din >> cnt));
      end
    end
    if (TAPS == W) begin : g_edge
      always_comb begin
        if (en && cnt == CNT_W'(TAPS - 1)) begin
          p_right_edge_r8: assert (dout == {{(W-1){1'b0}}, din[W-1]});
        end
      end
    end
  end
endmodule

// File: rtl/addshf_top.sv
`timescale 1ns/1ps
module addshf_top
  import addshf_pkg::*;
#(
  parameter int  DATA_W = DEF_DATA_W,
  localparam int CNT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [CNT_W-1:0]  shamt,
  input  logic              left_en,
  input  logic              right_en,
  output logic [DATA_W-1:0] left_out,
  output logic [DATA_W-1:0] right_out,
  output logic              carry_out
);
  logic [DATA_W-1:0] sum;

  addshf_adder #(.W(DATA_W)) u_adder (
    .a    (op_a),
    .b    (op_b),
    .sum  (sum),
    .cout (carry_out)
  );

  addshf_shifter #(.W(DATA_W), .CNT_W(CNT_W), .DIR(DIR_LEFT)) u_shl (
    .din  (sum),
    .cnt  (shamt),
    .en   (left_en),
    .dout (left_out)
  );

  addshf_shifter #(.W(DATA_W), .CNT_W(CNT_W), .DIR(DIR_RIGHT)) u_shr (
    .din  (sum),
    .cnt  (shamt),
    .en   (right_en),
    .dout (right_out)
  );

  always_comb begin : chk
    // R7: one bus enabled, the other disabled, must not leak into each other
    if (left_en && !right_en) begin
      p_independent_r7: assert (right_out == '0);
    end
  end
endmodule

// File: tb/addshf_top_bench.sv
`timescale 1ns/1ps
module addshf_top_bench;
  logic       clk = 1'b0;
  logic [3:0] op_a = '0;
  logic [3:0] op_b = '0;
  logic [1:0] shamt = '0;
  logic       left_en = 1'b0;
  logic       right_en = 1'b0;
  logic [3:0] left_out;
  logic [3:0] right_out;
  logic       carry_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  addshf_top u_addshf_top (
    .op_a      (op_a),
    .op_b      (op_b),
    .shamt     (shamt),
    .left_en   (left_en),
    .right_en  (right_en),
    .left_out  (left_out),
    .right_out (right_out),
    .carry_out (carry_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d n=%0d le=%0b re=%0b actual=%0d expected=%0d",
               tag, op_a, op_b, shamt, left_en, right_en, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input int n, input int le, input int re);
    @(negedge clk);
    op_a     = 4'(a);
    op_b     = 4'(b);
    shamt    = 2'(n);
    left_en  = 1'(le);
    right_en = 1'(re);
    @(posedge clk);
    #1;
  endtask

  task automatic compare(input int a, input int b, input int n, input int le, input int re);
    int s;
    int c;
    int exp_l;
    int exp_r;
    s     = (a + b) % 16;
    c     = (a + b) / 16;
    exp_l = le ? ((s << n) % 16) : 0;
    exp_r = re ? (s >> n) : 0;
    check("R2", int'(carry_out), c);
    if (!le)         check("R5", int'(left_out), 0);
    else if (n == 0) check("R9", int'(left_out), s);
    else if (n == 3) check("R8", int'(left_out), (s % 2) * 8);
    else             check("R3", int'(left_out), exp_l);
    if (!re)         check("R6", int'(right_out), 0);
    else if (n == 0) check("R9", int'(right_out), s);
    else if (n == 3) check("R8", int'(right_out), s / 8);
    else             check("R4", int'(right_out), exp_r);
    if (le && n == 0) check("R1", int'(left_out), s);
    if (le && re)     check("R7", int'({left_out, right_out}), exp_l * 16 + exp_r);
  endtask

  initial begin
    apply(0, 0, 0, 0, 0);
    check("R1", int'({carry_out, left_out, right_out}), 0);
    // directed corners
    apply(15, 1, 0, 1, 1);  check("R2", int'(carry_out), 1);
    check("R1", int'(left_out), 0);
    apply(5, 2, 3, 1, 1);   check("R8", int'(left_out), 8);
    check("R8", int'(right_out), 0);
    apply(6, 3, 3, 1, 1);   check("R8", int'(right_out), 1);
    apply(9, 6, 2, 0, 1);   check("R5", int'(left_out), 0);
    check("R4", int'(right_out), 3);
    apply(9, 6, 1, 1, 0);   check("R6", int'(right_out), 0);
    check("R3", int'(left_out), 14);
    // exhaustive sweep
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int n = 0; n < 4; n++)
          for (int e = 0; e < 4; e++) begin
            apply(a, b, n, e % 2, e / 2);
            compare(a, b, n, e % 2, e / 2);
          end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule